// File: doc/BRIEF.md
# Audio Channel-Status Change Notifier

This block gathers the channel-status bit of two audio channels, one bit per channel per audio frame, across a 192-frame status block. Frames arrive on a valid/ready stream. The block never applies back-pressure: `in_ready` is held high, and every cycle with `in_valid` high is one accepted frame. A frame whose start flag is set opens a new block and supplies bit 0 of each channel. The next 191 accepted frames supply bits 1 to 191.

When a block is complete, its leading bits are compared with the copy kept from the last accepted block. The new block then replaces that copy. From the stored copy, the block decodes the stream type, the copy-protection flag and the sampling-frequency code for each channel. If the content changed, the block sets a sticky update flag and pulls the active-low `notify_n` pin low. The host therefore does not need to poll. The host writes 1 through `clr_upd` to drop the flag, and the pin returns high.

Top module: `csn_notifier`

## Requirements
- R1: `in_ready` is always 1. A frame counts only in a cycle where `in_valid` is 1. With `in_valid` at 0, `in_start` and `in_cs` have no effect.
- R2: An accepted frame with `in_start`=1 holds bit 0 of each channel. The following accepted frames hold bits 1 to 191, and the 192nd frame closes the block. Accepted frames that arrive before any block has opened are ignored.
- R3: Channel A uses bit 0 of `in_cs` and of each decoded vector, and channel B uses bit 1. `non_pcm` is status bit 1 (1 = compressed). `copy_prot` is status bit 2. Each 4-bit group of `fs_code` is status bits 24..27, with bit 24 as the LSB. Channel A's group is `fs_code[3:0]`. All of these are decoded from the stored copy.
- R4: The first complete block after reset is stored and decoded, but it never sets the update flag.
- R5: Every later complete block sets the update flag if, and only if, any of status bits 0..39 of either channel differs from the stored copy. Bits 40..191 play no part in the comparison.
- R6: The update flag stays set until a cycle with `clr_upd`=1. `notify_n` is 0 exactly while the flag is 1.
- R7: If a change is detected in the same cycle as `clr_upd`=1, the flag ends up set.
- R8: A start frame that arrives before the current block is complete discards the partial block. The stored copy and the decoded fields stay unchanged, and a new block opens.
- R9: After reset the flag is 0, `notify_n` is 1, and all decoded fields are 0.
- R10: The flag and the decoded fields change on the clock edge after the edge that accepts the block's last frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Frame valid |
| in_ready | output | 1 | Frame ready, always 1 |
| in_start | input | 1 | Frame opens a status block |
| in_cs | input | 2 | Status bit per channel (bit 0 = A) |
| clr_upd | input | 1 | Write-1 clear of the update flag |
| upd_flag | output | 1 | Sticky status-change flag |
| notify_n | output | 1 | Active-low change notification |
| non_pcm | output | 2 | Compressed-stream flag per channel |
| copy_prot | output | 2 | Copy-protection flag per channel |
| fs_code | output | 8 | Sampling-frequency code, 4 bits per channel |

## Verification
A completed block that differs from the stored copy can be judged in the same cycle as a host clear. The bench provokes this by holding `clr_upd` high in the cycle right after the last frame of a changed block is accepted. It then expects the flag to stay set and `notify_n` to stay low; only a later clear on its own releases them. A separate check samples the outputs one edge after the final frame, where they must still be old, and again one edge later, where they must carry the new values.

// File: rtl/csn_pkg.sv
package csn_pkg;
  localparam int unsigned CSN_NCH = 2;
  localparam int unsigned CSN_BLOCK_LEN = 192;
  localparam int unsigned CSN_CMP_BITS = 40;
  localparam int unsigned CSN_NPCM_POS = 1;
  localparam int unsigned CSN_COPY_POS = 2;
  localparam int unsigned CSN_FS_LSB = 24;
  localparam int unsigned CSN_FS_W = 4;
endpackage

// File: rtl/csn_frame_track.sv
module csn_frame_track #(
  parameter int unsigned BLOCK_LEN = 192,
  localparam int unsigned CW = $clog2(BLOCK_LEN)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          start,
  output logic          wr_en,
  output logic [CW-1:0] idx,
  output logic          done
);
  logic          in_blk;
  logic [CW-1:0] cnt;

  always_comb begin
    wr_en = acc && (start || in_blk);
    idx   = start ? '0 : cnt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_blk <= 1'b0;
      cnt    <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (acc) begin
        if (start) begin
          in_blk <= 1'b1;
          cnt    <= CW'(1);
        end else if (in_blk) begin
          if (cnt == CW'(BLOCK_LEN - 1)) begin
            in_blk <= 1'b0;
            cnt    <= '0;
            done   <= 1'b1;
          end else begin
            cnt <= cnt + CW'(1);
          end
        end
      end
    end
  end

  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(BLOCK_LEN - 1));
  assert_done_closes_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_blk);
  assert_idle_ignored_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !acc |=> $stable(in_blk));
endmodule

// File: rtl/csn_capture.sv
module csn_capture #(
  parameter int unsigned BLOCK_LEN = 192,
  parameter int unsigned CMP_BITS  = 40,
  localparam int unsigned CW = $clog2(BLOCK_LEN),
  localparam int unsigned IW = $clog2(CMP_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [CW-1:0]       idx,
  input  logic                bit_in,
  output logic [CMP_BITS-1:0] word
);
  logic in_win;

  always_comb in_win = wr_en && (int'(idx) < CMP_BITS);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word <= '0;
    end else if (in_win) begin
      word[IW'(idx)] <= bit_in;
    end
  end

  assert_window_only_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(word));
endmodule

// File: rtl/csn_compare.sv
module csn_compare #(
  parameter int unsigned NCH      = 2,
  parameter int unsigned CMP_BITS = 40
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          done,
  input  logic [NCH-1:0][CMP_BITS-1:0]  cap,
  input  logic                          clr,
  output logic                          upd_flag,
  output logic                          notify_n,
  output logic [NCH-1:0][CMP_BITS-1:0]  stored
);
  logic have_ref;
  logic differ;
  logic set_upd;
  logic upd_nxt;

  always_comb begin
    differ  = (cap != stored);
    set_upd = done && have_ref && differ;
    upd_nxt = set_upd || (upd_flag && !clr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      have_ref <= 1'b0;
      stored   <= '0;
      upd_flag <= 1'b0;
      notify_n <= 1'b1;
    end else begin
      upd_flag <= upd_nxt;
      notify_n <= !upd_nxt;
      if (done) begin
        stored   <= cap;
        have_ref <= 1'b1;
      end
    end
  end

  assert_first_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !have_ref |-> !upd_flag);
  assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    upd_flag && !clr |=> upd_flag);
  assert_pin_tracks_R6: assert property (@(posedge clk) disable iff (!rst_n)
    notify_n == !upd_flag);
  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(stored));
  assert_latch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> stored == $past(cap));
endmodule

// File: rtl/csn_notifier.sv
module csn_notifier
  import csn_pkg::*;
#(
  parameter int unsigned NCH       = CSN_NCH,
  parameter int unsigned BLOCK_LEN = CSN_BLOCK_LEN,
  parameter int unsigned CMP_BITS  = CSN_CMP_BITS,
  parameter int unsigned NPCM_POS  = CSN_NPCM_POS,
  parameter int unsigned COPY_POS  = CSN_COPY_POS,
  parameter int unsigned FS_LSB    = CSN_FS_LSB,
  parameter int unsigned FS_W      = CSN_FS_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_start,
  input  logic [NCH-1:0]    in_cs,
  input  logic              clr_upd,
  output logic              upd_flag,
  output logic              notify_n,
  output logic [NCH-1:0]    non_pcm,
  output logic [NCH-1:0]    copy_prot,
  output logic [NCH*FS_W-1:0] fs_code
);
  localparam int unsigned CW = $clog2(BLOCK_LEN);

  logic                         wr_en;
  logic [CW-1:0]                idx;
  logic                         done;
  logic [NCH-1:0][CMP_BITS-1:0] cap;
  logic [NCH-1:0][CMP_BITS-1:0] stored;

  assign in_ready = 1'b1;

  csn_frame_track #(.BLOCK_LEN(BLOCK_LEN)) track_i (
    .clk(clk), .rst_n(rst_n), .acc(in_valid), .start(in_start),
    .wr_en(wr_en), .idx(idx), .done(done)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    csn_capture #(.BLOCK_LEN(BLOCK_LEN), .CMP_BITS(CMP_BITS)) cap_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .idx(idx),
      .bit_in(in_cs[g]), .word(cap[g])
    );
    assign non_pcm[g]              = stored[g][NPCM_POS];
    assign copy_prot[g]            = stored[g][COPY_POS];
    assign fs_code[g*FS_W +: FS_W] = stored[g][FS_LSB +: FS_W];
  end

  csn_compare #(.NCH(NCH), .CMP_BITS(CMP_BITS)) cmp_i (
    .clk(clk), .rst_n(rst_n), .done(done), .cap(cap), .clr(clr_upd),
    .upd_flag(upd_flag), .notify_n(notify_n), .stored(stored)
  );
endmodule

// File: tb/csn_notifier_tb.sv
module csn_notifier_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, clr_upd = 1'b0;
  logic [1:0] in_cs = 2'b00;
  logic in_ready, upd_flag, notify_n;
  logic [1:0] non_pcm, copy_prot;
  logic [7:0] fs_code;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  csn_notifier dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_cs(in_cs), .clr_upd(clr_upd),
    .upd_flag(upd_flag), .notify_n(notify_n), .non_pcm(non_pcm),
    .copy_prot(copy_prot), .fs_code(fs_code)
  );

  // {trunc, gap, hi39B, hi100B, npA, cpA, fsA[4], npB, cpB, fsB[4], exp_upd}
  localparam logic [16:0] VEC [8] = '{
    {4'b0000, 1'b0, 1'b0, 4'h2, 1'b1, 1'b1, 4'h3, 1'b0},
    {4'b0100, 1'b0, 1'b0, 4'h2, 1'b1, 1'b1, 4'h3, 1'b0},
    {4'b0000, 1'b0, 1'b0, 4'hA, 1'b1, 1'b1, 4'h3, 1'b1},
    {4'b0000, 1'b0, 1'b0, 4'hA, 1'b1, 1'b1, 4'h3, 1'b0},
    {4'b0010, 1'b0, 1'b0, 4'hA, 1'b1, 1'b1, 4'h3, 1'b1},
    {4'b0011, 1'b0, 1'b0, 4'hA, 1'b1, 1'b1, 4'h3, 1'b0},
    {4'b1011, 1'b1, 1'b0, 4'hA, 1'b1, 1'b1, 4'h3, 1'b0},
    {4'b0111, 1'b0, 1'b0, 4'hA, 1'b1, 1'b1, 4'h3, 1'b0}
  };

  logic [1:0] m_np = '0, m_cp = '0;
  logic [7:0] m_fs = '0;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic cs_bit(int k, logic np, logic cp, logic [3:0] fs, logic h39, logic h100);
    if (k == 1) return np;
    if (k == 2) return cp;
    if (k >= 24 && k <= 27) return fs[k-24];
    if (k == 39) return h39;
    if (k == 100) return h100;
    return 1'b0;
  endfunction

  task automatic frame(input logic st, input logic [1:0] cs, input bit gap);
    if (gap) begin
      @(negedge clk);
      in_valid = 1'b0; in_start = 1'b1; in_cs = 2'b11;
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b1; in_start = st; in_cs = cs;
    @(posedge clk);
  endtask

  task automatic send_block(input logic [16:0] v);
    int len = v[16] ? 100 : 192;
    for (int k = 0; k < len; k++)
      frame(k == 0, {cs_bit(k, v[6], v[5], v[4:1], v[14], v[13]),
                     cs_bit(k, v[12], v[11], v[10:7], 1'b0, 1'b0)}, v[15]);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0; in_cs = 2'b00;
  endtask

  task automatic clear_pulse();
    @(negedge clk); clr_upd = 1'b1;
    @(negedge clk); clr_upd = 1'b0;
  endtask

  task automatic check_fields(input string req);
    check(non_pcm == m_np, req, non_pcm, m_np);
    check(copy_prot == m_cp, req, copy_prot, m_cp);
    check(fs_code == m_fs, req, fs_code, m_fs);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // R9 reset state, R1 ready
    check(upd_flag == 1'b0, "R9 flag", upd_flag, 0);
    check(notify_n == 1'b1, "R9 notify_n", notify_n, 1);
    check_fields("R9 fields");
    check(in_ready == 1'b1, "R1 ready", in_ready, 1);
    // R2: frames before any start are ignored
    for (int k = 0; k < 250; k++) frame(1'b0, 2'b11, 1'b0);
    @(negedge clk); in_valid = 1'b0;
    @(negedge clk);
    check(upd_flag == 1'b0, "R2 no block", upd_flag, 0);
    check_fields("R2 no block");

    // table walk: R1 R3 R4 R5 R8
    for (int e = 0; e < 8; e++) begin
      logic [16:0] v = VEC[e];
      clear_pulse();
      send_block(v);
      @(negedge clk);
      if (!v[16]) begin
        m_np = {v[6], v[12]}; m_cp = {v[5], v[11]}; m_fs = {v[4:1], v[10:7]};
      end
      check(upd_flag == v[0], $sformatf("R5/R4/R8 vec%0d flag", e), upd_flag, v[0]);
      check(notify_n == !v[0], $sformatf("R6 vec%0d notify_n", e), notify_n, !v[0]);
      check_fields($sformatf("R3 vec%0d fields", e));
    end

    // R10 timing and R7 set-vs-clear collision
    for (int k = 0; k < 192; k++)
      frame(k == 0, {cs_bit(k, 1'b1, 1'b1, 4'h3, 1'b1, 1'b1),
                     cs_bit(k, 1'b0, 1'b0, 4'hB, 1'b0, 1'b0)}, 1'b0);
    @(negedge clk);
    in_valid = 1'b0; in_start = 1'b0;
    check(upd_flag == 1'b0, "R10 not early", upd_flag, 0);
    check(fs_code == m_fs, "R10 fields not early", fs_code, m_fs);
    clr_upd = 1'b1;
    @(negedge clk);
    clr_upd = 1'b0;
    m_fs = 8'h3B;
    check(upd_flag == 1'b1, "R7 set wins", upd_flag, 1);
    check(notify_n == 1'b0, "R7 notify_n low", notify_n, 0);
    check(fs_code == m_fs, "R10 fields update", fs_code, m_fs);
    repeat (3) @(negedge clk);
    check(upd_flag == 1'b1, "R6 sticky", upd_flag, 1);
    clear_pulse();
    check(upd_flag == 1'b0, "R6 cleared", upd_flag, 0);
    check(notify_n == 1'b1, "R6 notify_n high", notify_n, 1);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule